// File: doc/BRIEF.md
# Self-Terminating Serial Frame Receiver

This block turns an asynchronous serial line into parallel bytes. It expects frames of eleven bits: a low start bit, eight data bits sent least significant bit first, one parity bit and a high stop bit. The line idles high. The block has no bit counter. A run flag passes a sampling strobe to a ten-stage shift register, and the start bit is shifted in together with the data. Ten strobes later the start bit's zero reaches the final stage. That zero drops the run flag, and the frame ends there.

The bit rate comes from a tick input that pulses once per bit period. The block measures the number of system clocks between two ticks. After a falling edge on the synchronised line it waits half of that period, so that every bit is sampled near its centre. Two debug inputs force the run flag on or off, and they take priority over the automatic control. All logic runs on one clock, with clock enables and no gated clocks.

Top module: `shiftreg_uart_rx`

## Requirements
- R1: While rst_n is low at a clock edge, rx_data, rx_valid and parity_err are driven to 0 and shift_en to 0.
- R2: A frame is armed only by a high-to-low transition of the RX line after the two-flop synchroniser, seen while shift_en is 0. The run flag sets half a bit period later only if the line is still low. A low pulse shorter than half a bit period produces no shift_en and no rx_valid.
- R3: rx_data carries the eight data bits of the frame. The first data bit on the line becomes bit 0 and the last becomes bit 7.
- R4: After the tenth sampling strobe of a frame the run flag clears by itself. rx_valid then pulses high for exactly one clock, and shift_en falls on the same edge.
- R5: Parity is even by default, so the eight data bits and the parity bit together hold an even number of ones. parity_err is updated together with each rx_valid: it is 1 when the check fails and 0 when it passes, and it holds its value between frames.
- R6: When the run flag clears, a low parity bit that is still on the line does not set the flag again. Each frame raises shift_en exactly once, and shift_en is 0 after the stop bit.
- R7: A one-cycle man_set pulse makes shift_en 1 on the next clock, and it stays 1 while only ones are shifted in. A man_clr pulse makes shift_en 0 on the next clock, throws away the partial frame without an rx_valid pulse, and takes priority over man_set.
- R8: The bit period is measured as the number of clocks between two consecutive bit_tick pulses. Until two ticks have been seen after reset, activity on the RX line is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-clock pulse once per bit period; sets the bit rate |
| rx_in | input | 1 | Asynchronous serial input line, idles high |
| man_set | input | 1 | Debug request that forces the run flag on |
| man_clr | input | 1 | Debug request that forces the run flag off (wins over man_set) |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-clock pulse when a frame completes |
| parity_err | output | 1 | Parity check result of the last frame, 1 on mismatch |
| shift_en | output | 1 | Current state of the run flag |

## Verification
The shift register also acts as the frame counter, so a stage that is lost or shifted the wrong way changes the frame length. That shows within the same frame: rx_valid pulses early or late, the byte comes out rotated, or parity_err is wrong. A run flag that fails to clear, or that sets again during a low parity bit, leaves shift_en high after the stop bit, or raises it a second time. That appears within one bit period of the end of the frame. A wrong half-period delay or a bad rate measurement samples the bits off-centre. The random bytes then come out corrupted on the first frame.

// File: rtl/uart_sr_pkg.sv
// Package: shared types for the self-terminating serial receiver.
// Assumes: nothing beyond being compiled before the modules that import it.
package uart_sr_pkg;

    // States of the run-flag controller
    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,   // waiting for a falling edge on the line
        GATE_ARM  = 2'd1,   // half-bit wait before the start bit is sampled
        GATE_RUN  = 2'd2    // run flag set; strobes reach the shift register
    } gate_state_t;

endpackage

// File: rtl/rx_bit_sync.sv
// Module: rx_bit_sync
// Brings an asynchronous level into the clk domain through a chain of flops.
// Assumes: STAGES >= 2; reset loads the idle level so that no false edge
// appears when reset is released.
module rx_bit_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] pipe_q;

    // Shift the raw level through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{IDLE_LVL}};
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/rx_rate_learn.sv
// Module: rx_rate_learn
// Counts the system clocks between consecutive bit_tick pulses and keeps the
// result as the bit period. period_vld rises after the second tick.
// Assumes: ticks are one clock wide and the period fits in CNT_W bits; the
// gap counter saturates instead of wrapping.
module rx_rate_learn #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    output logic [CNT_W-1:0] period,
    output logic             period_vld
);

    logic [CNT_W-1:0] gap_cnt;
    logic             seen_tick;

    // Measure the gap between ticks and store it on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt    <= '0;
            seen_tick  <= 1'b0;
            period     <= '0;
            period_vld <= 1'b0;
        end else if (bit_tick) begin
            gap_cnt   <= '0;
            seen_tick <= 1'b1;
            if (seen_tick) begin
                period     <= gap_cnt + 1'b1;
                period_vld <= 1'b1;
            end
        end else if (gap_cnt != '1) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // R8
    rate_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && seen_tick) |=> period_vld);

    // R8
    rate_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_tick |=> !period_vld);

endmodule

// File: rtl/rx_enable_gate.sv
// Module: rx_enable_gate
// Controls the run flag. A falling edge on the synchronised line arms the
// gate. Half a bit period later the start level is checked again. If it is
// still low, the flag sets and the first strobe samples the start bit. While
// the flag is set, a strobe fires once per bit period. The flag clears when
// the shift register reports that the start bit has reached its last stage.
// The manual inputs override this: clear wins over set.
// Assumes: period >= 4 clocks and period_vld is 1 before any frame arrives.
module rx_enable_gate
    import uart_sr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_s,
    input  logic [CNT_W-1:0] period,
    input  logic             period_vld,
    input  logic             man_set,
    input  logic             man_clr,
    input  logic             term_hit,
    output logic             shift_en,
    output logic             shift_strobe,
    output logic             frame_done,
    output logic             sr_preset
);

    gate_state_t      state_q;
    logic [CNT_W-1:0] ph_q;
    logic [CNT_W:0]   ph_next;
    logic [CNT_W-1:0] half_per;
    logic             rx_prev_q;
    logic             line_fall;
    logic             arm_due;
    logic             run_due;

    // Derive the edge, the half-bit point and the bit-period point
    always_comb begin
        ph_next      = {1'b0, ph_q} + 1'b1;
        half_per     = period >> 1;
        line_fall    = rx_prev_q & ~rx_s;
        arm_due      = (state_q == GATE_ARM) && (ph_next >= {1'b0, half_per});
        run_due      = (state_q == GATE_RUN) && (ph_next >= {1'b0, period});
        frame_done   = (state_q == GATE_RUN) && term_hit && !man_set && !man_clr;
        shift_strobe = (arm_due && !rx_s && !man_clr && !man_set)
                     || (run_due && !man_clr && !frame_done);
        sr_preset    = frame_done || man_clr;
        shift_en     = (state_q == GATE_RUN);
    end

    // Remember the previous line level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prev_q <= 1'b1;
        end else begin
            rx_prev_q <= rx_s;
        end
    end

    // Advance the run-flag state machine and its phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_IDLE;
            ph_q    <= '0;
        end else if (man_clr) begin
            state_q <= GATE_IDLE;
            ph_q    <= '0;
        end else if (man_set && state_q != GATE_RUN) begin
            state_q <= GATE_RUN;
            ph_q    <= '0;
        end else begin
            case (state_q)
                GATE_IDLE: begin
                    if (line_fall && period_vld) begin
                        state_q <= GATE_ARM;
                        ph_q    <= '0;
                    end
                end
                GATE_ARM: begin
                    if (arm_due) begin
                        state_q <= rx_s ? GATE_IDLE : GATE_RUN;
                        ph_q    <= '0;
                    end else begin
                        ph_q <= ph_next[CNT_W-1:0];
                    end
                end
                GATE_RUN: begin
                    if (frame_done) begin
                        state_q <= GATE_IDLE;
                        ph_q    <= '0;
                    end else if (run_due) begin
                        ph_q <= '0;
                    end else begin
                        ph_q <= ph_next[CNT_W-1:0];
                    end
                end
                default: begin
                    state_q <= GATE_IDLE;
                    ph_q    <= '0;
                end
            endcase
        end
    end

    // R2 R6
    arm_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_ARM && $past(state_q) == GATE_IDLE)
            |-> ($past(rx_prev_q) && !$past(rx_s)));

    // R2
    glitch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_due && rx_s && !man_set && !man_clr) |=> !shift_en);

    // R7
    man_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        man_clr |=> !shift_en);

    // R7
    man_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (man_set && !man_clr) |=> shift_en);

    // R4
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!shift_en && !shift_strobe));

endmodule

// File: rtl/rx_shift_frame.sv
// Module: rx_shift_frame
// A shift register of DATA_W+2 stages. The start bit, the data bits and the
// parity bit enter at the top stage and move toward stage 0. The start bit's
// zero at stage 0 marks a complete frame. Preset loads all ones, so that a
// new frame is counted from a clean state.
// Assumes: preset and strobe are never both requested for a useful shift;
// preset wins.
module rx_shift_frame #(
    parameter int DATA_W     = 8,
    parameter bit ODD_PARITY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_strobe,
    input  logic              sr_preset,
    input  logic              bit_in,
    output logic              term_hit,
    output logic [DATA_W-1:0] frame_data,
    output logic              parity_bad
);

    localparam int STAGES = DATA_W + 2;

    logic [STAGES-1:0] sr_q;
    logic              par_sum;

    // Load ones on preset, otherwise shift one sample in per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '1;
        end else if (sr_preset) begin
            sr_q <= '1;
        end else if (shift_strobe) begin
            sr_q <= {bit_in, sr_q[STAGES-1:1]};
        end
    end

    // Fold data and parity bits into one sum bit
    always_comb begin
        par_sum = ^sr_q[STAGES-1:1];
    end

    // Pick the parity sense at elaboration time
    generate
        if (ODD_PARITY) begin : g_odd
            assign parity_bad = ~par_sum;
        end else begin : g_even
            assign parity_bad = par_sum;
        end
    endgenerate

    assign term_hit   = ~sr_q[0];
    assign frame_data = sr_q[DATA_W:1];

    // R3
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_strobe && !sr_preset) |=> (sr_q[STAGES-1] == $past(bit_in)));

    // R4
    preset_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_preset |=> (sr_q == '1));

endmodule

// File: rtl/shiftreg_uart_rx.sv
// Module: shiftreg_uart_rx (top)
// A serial frame receiver that ends each frame by itself. It chains a
// synchroniser, a bit-rate meter, the run-flag gate and the frame shift
// register, and registers the byte, the valid pulse and the parity result.
// Assumes: frames are start + DATA_W data bits (LSB first) + parity + stop,
// and bit_tick pulses once per bit period.
module shiftreg_uart_rx #(
    parameter int DATA_W      = 8,
    parameter bit ODD_PARITY  = 1'b0,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              rx_in,
    input  logic              man_set,
    input  logic              man_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              parity_err,
    output logic              shift_en
);

    logic              rx_s;
    logic [CNT_W-1:0]  period;
    logic              period_vld;
    logic              term_hit;
    logic              shift_strobe;
    logic              frame_done;
    logic              sr_preset;
    logic [DATA_W-1:0] frame_data;
    logic              parity_bad;

    rx_bit_sync #(
        .STAGES   (SYNC_STAGES),
        .IDLE_LVL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_in),
        .q_sync  (rx_s)
    );

    rx_rate_learn #(
        .CNT_W (CNT_W)
    ) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .period     (period),
        .period_vld (period_vld)
    );

    rx_enable_gate #(
        .CNT_W (CNT_W)
    ) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_s         (rx_s),
        .period       (period),
        .period_vld   (period_vld),
        .man_set      (man_set),
        .man_clr      (man_clr),
        .term_hit     (term_hit),
        .shift_en     (shift_en),
        .shift_strobe (shift_strobe),
        .frame_done   (frame_done),
        .sr_preset    (sr_preset)
    );

    rx_shift_frame #(
        .DATA_W     (DATA_W),
        .ODD_PARITY (ODD_PARITY)
    ) u_shreg (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift_strobe (shift_strobe),
        .sr_preset    (sr_preset),
        .bit_in       (rx_s),
        .term_hit     (term_hit),
        .frame_data   (frame_data),
        .parity_bad   (parity_bad)
    );

    // Capture the byte and the parity result when a frame completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
        end else begin
            rx_valid <= frame_done;
            if (frame_done) begin
                rx_data    <= frame_data;
                parity_err <= parity_bad;
            end
        end
    end

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R4
    auto_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(shift_en) && !$past(man_clr)) |-> rx_valid);

    // R3 R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(parity_err)));

endmodule

// File: tb/shiftreg_uart_rx_tb.sv
module shiftreg_uart_rx_tb;

    localparam int BITC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       man_set = 1'b0;
    logic       man_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       parity_err;
    logic       shift_en;

    int         checks = 0;
    int         errors = 0;
    int         vcount = 0;
    int         en_rises = 0;
    logic [7:0] last_data = 8'h00;
    logic       last_perr = 1'b0;
    logic       en_q = 1'b0;
    logic       tick_run = 1'b0;
    int         tick_cnt = 0;

    always #5 clk = ~clk;

    shiftreg_uart_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .rx_in      (rx_in),
        .man_set    (man_set),
        .man_clr    (man_clr),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .parity_err (parity_err),
        .shift_en   (shift_en)
    );

    // Bit-rate tick source, driven away from the active edge
    always @(negedge clk) begin
        if (tick_run) begin
            if (tick_cnt == BITC - 1) begin
                tick_cnt <= 0;
                bit_tick <= 1'b1;
            end else begin
                tick_cnt <= tick_cnt + 1;
                bit_tick <= 1'b0;
            end
        end else begin
            bit_tick <= 1'b0;
        end
    end

    // Port monitor: count valid pulses and rising edges of shift_en
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                vcount    <= vcount + 1;
                last_data <= rx_data;
                last_perr <= parity_err;
            end
            if (shift_en && !en_q) en_rises <= en_rises + 1;
            en_q <= shift_en;
        end
    end

    function automatic logic even_par(input logic [7:0] d);
        return ^d;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rx_in = b;
        idle(BITC);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(even_par(d) ^ bad);
        send_bit(1'b1);
    endtask

    task automatic frame_check(input logic [7:0] d, input logic bad);
        int v0;
        int r0;
        v0 = vcount;
        r0 = en_rises;
        send_frame(d, bad);
        idle(2);
        check(vcount == v0 + 1, "R4 valid count", vcount - v0, 1);
        check(last_data == d, "R3 data byte", last_data, d);
        check(last_perr == bad, "R5 parity flag", last_perr, bad);
        check(en_rises == r0 + 1, "R6 single enable per frame", en_rises - r0, 1);
        check(shift_en == 1'b0, "R6 enable clear after stop", shift_en, 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        int unsigned seed;
        int v0;
        int r0;
        seed = $urandom(32'd1977);

        // R1: reset state
        idle(5);
        check(rx_data == 8'h00, "R1 data reset", rx_data, 0);
        check(rx_valid == 1'b0, "R1 valid reset", rx_valid, 0);
        check(parity_err == 1'b0, "R1 perr reset", parity_err, 0);
        check(shift_en == 1'b0, "R1 enable reset", shift_en, 0);
        rst_n = 1'b1;
        idle(4);

        // R8: no rate learned yet, line activity ignored
        rx_in = 1'b0;
        idle(3 * BITC);
        rx_in = 1'b1;
        idle(20);
        check(en_rises == 0, "R8 no enable before ticks", en_rises, 0);
        check(vcount == 0, "R8 no valid before ticks", vcount, 0);

        tick_run = 1'b1;
        idle(3 * BITC);

        // Directed frames (0x00 has a low parity bit: R6)
        frame_check(8'h00, 1'b0);
        frame_check(8'hFF, 1'b0);
        frame_check(8'h01, 1'b0);
        frame_check(8'h80, 1'b0);
        frame_check(8'hA5, 1'b1);
        frame_check(8'h3C, 1'b0);

        // R2: short low glitch must not start a frame
        v0 = vcount;
        r0 = en_rises;
        rx_in = 1'b0;
        idle(4);
        rx_in = 1'b1;
        idle(3 * BITC);
        check(en_rises == r0, "R2 glitch enable", en_rises - r0, 0);
        check(vcount == v0, "R2 glitch valid", vcount - v0, 0);

        // R7: manual clear mid-frame discards it
        v0 = vcount;
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b1);
        man_clr = 1'b1;
        @(negedge clk);
        man_clr = 1'b0;
        check(shift_en == 1'b0, "R7 manual clear", shift_en, 0);
        idle(12 * BITC);
        check(vcount == v0, "R7 no valid after manual clear", vcount - v0, 0);
        frame_check(8'h96, 1'b0);

        // R7: manual set holds enable while only ones shift in
        v0 = vcount;
        man_set = 1'b1;
        @(negedge clk);
        man_set = 1'b0;
        check(shift_en == 1'b1, "R7 manual set", shift_en, 1);
        idle(12 * BITC);
        check(shift_en == 1'b1, "R7 enable held on ones", shift_en, 1);
        check(vcount == v0, "R7 no valid while set", vcount - v0, 0);
        man_set = 1'b1;
        man_clr = 1'b1;
        @(negedge clk);
        man_set = 1'b0;
        man_clr = 1'b0;
        check(shift_en == 1'b0, "R7 clear wins over set", shift_en, 0);
        idle(BITC);
        frame_check(8'h5A, 1'b0);

        // Random frames with random gaps and parity faults
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d;
            logic       bad;
            d   = 8'($urandom_range(0, 255));
            bad = ($urandom_range(0, 4) == 0);
            frame_check(d, bad);
            idle($urandom_range(0, 40));
        end

        finish_run();
    end

endmodule